// File: doc/BRIEF.md
# Scaled-Index Load/Store Address Unit

This unit sits in the decode-to-memory path of a simple pipeline. It looks at a 32-bit register-format instruction word and picks out two memory instructions, an indexed load and an indexed store. Both take their element stride from the 5-bit shift-amount field. For either one it combines the base operand and the index operand into the effective address base + index × stride. That address calculation takes the place of a separate multiply, add and load.

The address, a one-cycle load or store strobe and the element register number are registered one clock after a valid instruction is presented. A valid word that is neither of the two instructions raises a not-recognised flag for one cycle instead. The register file, the memory system and hazard control are outside the block.

Top module: `sidx_agu`

## Requirements
- R1: Bits [31:26] of the instruction are the opcode, and they must be zero. Bits [5:0] are the function code. With instr_valid high, code 0x38 gives a one-cycle load_stb pulse on the following clock, and code 0x39 gives a one-cycle store_stb pulse on the following clock.
- R2: For a recognised instruction, eff_addr on the following clock equals base_val + index_val × stride, taken modulo 2^32. base_val carries the register that bits [25:21] select, and index_val carries the register that bits [20:16] select.
- R3: The stride is the value of bits [10:6] when that value is 1 to 31. A value of 0 in those bits means a stride of 32.
- R4: For a recognised instruction, elem_reg on the following clock equals bits [15:11] of the instruction.
- R5: A valid word with a nonzero opcode, or with a function code other than 0x38 and 0x39, sets unknown_op high for one clock. In that clock both strobes are low, and eff_addr and elem_reg keep their previous values.
- R6: When instr_valid is low, the next clock has load_stb, store_stb and unknown_op low, and eff_addr and elem_reg unchanged, whatever the instruction bits are.
- R7: While rst_n is low, eff_addr, elem_reg, load_stb, store_stb and unknown_op are all zero.
- R8: Instructions presented on consecutive clocks each produce their own result exactly one clock later, with no gap and no merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Value of the base register |
| index_val | input | 32 | Value of the index register |
| eff_addr | output | 32 | Registered effective address |
| elem_reg | output | 5 | Registered element register number |
| load_stb | output | 1 | Indexed load accepted last cycle |
| store_stb | output | 1 | Indexed store accepted last cycle |
| unknown_op | output | 1 | Valid word last cycle was not recognised |

## Verification
A vector table covers the stride extremes: 1, 31, and the zero encoding that means 32. It also covers a zero index, an all-ones index and sums that wrap past 2^32. Loads and stores are mixed in the table, so a swapped strobe or a misread field shows up as a wrong pulse or a wrong address. The table rows run back to back, so any extra pipeline stage or a dropped instruction shifts every later result. Directed cases follow a known load with three kinds of stimulus that must not disturb it: an unknown function code, a nonzero opcode and a low valid bit. Each of these must leave the held address and register number unchanged.

// File: rtl/sidx_agu.sv
module sidx_agu #(
  parameter int XLEN        = 32,
  parameter int REGW        = 5,
  parameter int SHW         = 5,
  parameter logic [5:0] FUNC_LOAD  = 6'h38,
  parameter logic [5:0] FUNC_STORE = 6'h39
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] base_val,
  input  logic [XLEN-1:0] index_val,
  output logic [XLEN-1:0] eff_addr,
  output logic [REGW-1:0] elem_reg,
  output logic            load_stb,
  output logic            store_stb,
  output logic            unknown_op
);

  localparam int STW = SHW + 1;

  logic [5:0]      opcode, funct;
  logic [SHW-1:0]  sh;
  logic [STW-1:0]  stride;
  logic            is_ld, is_st, hit;
  logic [XLEN-1:0] pp [STW];
  logic [XLEN-1:0] sum [STW+1];

  assign opcode = instr[31:26];
  assign funct  = instr[5:0];
  assign sh     = instr[10:6];
  assign stride = (sh == '0) ? STW'(1 << SHW) : {1'b0, sh};
  assign is_ld  = instr_valid && opcode == 6'd0 && funct == FUNC_LOAD;
  assign is_st  = instr_valid && opcode == 6'd0 && funct == FUNC_STORE;
  assign hit    = is_ld || is_st;

  assign sum[0] = base_val;
  for (genvar i = 0; i < STW; i++) begin : g_pp
    assign pp[i]    = stride[i] ? (index_val << i) : '0;
    assign sum[i+1] = sum[i] + pp[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_addr   <= '0;
      elem_reg   <= '0;
      load_stb   <= 1'b0;
      store_stb  <= 1'b0;
      unknown_op <= 1'b0;
    end else begin
      load_stb   <= is_ld;
      store_stb  <= is_st;
      unknown_op <= instr_valid && !hit;
      if (hit) begin
        eff_addr <= sum[STW];
        elem_reg <= instr[15:11];
      end
    end
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_stb, store_stb, unknown_op}));

  // R2
  addr_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> eff_addr == XLEN'($past(base_val) + $past(index_val) *
      (($past(instr[10:6]) == 5'd0) ? XLEN'(32) : XLEN'($past(instr[10:6])))));

  // R5
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stb || store_stb) |-> $stable(eff_addr) && $stable(elem_reg));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !load_stb && !store_stb && !unknown_op);

endmodule

// File: tb/sidx_agu_tb.sv
module sidx_agu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  localparam logic [31:0] V_BASE [NV] = '{32'h0000_1000, 32'h8000_0000, 32'hFFFF_FFF0, 32'h0000_0000,
                                           32'h1234_5678, 32'h0000_0040, 32'hFFFF_FFFF, 32'h0100_0000};
  localparam logic [31:0] V_IDX  [NV] = '{32'd3, 32'd7, 32'd1, 32'hFFFF_FFFF,
                                           32'd0, 32'd100, 32'd2, 32'h0800_0001};
  localparam logic [4:0]  V_SH   [NV] = '{5'd4, 5'd1, 5'd31, 5'd0, 5'd12, 5'd0, 5'd3, 5'd5};
  localparam logic [4:0]  V_RD   [NV] = '{5'd1, 5'd31, 5'd2, 5'd17, 5'd9, 5'd0, 5'd30, 5'd12};
  localparam logic [NV-1:0] V_ST = 8'b1010_0110;

  logic clk = 0, rst_n = 0, instr_valid = 0;
  logic [31:0] instr = 0, base_val = 0, index_val = 0;
  logic [31:0] eff_addr;
  logic [4:0]  elem_reg;
  logic load_stb, store_stb, unknown_op;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sidx_agu dut_i (.clk, .rst_n, .instr_valid, .instr, .base_val, .index_val,
                  .eff_addr, .elem_reg, .load_stb, .store_stb, .unknown_op);

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rd, logic [4:0] sh, logic [5:0] fn);
    return {op, 5'd4, 5'd5, rd, sh, fn};
  endfunction

  function automatic logic [31:0] ea(logic [31:0] b, logic [31:0] i, logic [4:0] sh);
    logic [31:0] s = (sh == 0) ? 32'd32 : {27'd0, sh};
    return b + i * s;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] w, logic [31:0] b, logic [31:0] i);
    instr_valid = v; instr = w; base_val = b; index_val = i;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_bad++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] hold_a;
    logic [4:0]  hold_r;
    drive(1, mk(0, 5'd7, 5'd3, 6'h38), 32'hFF, 32'h1);
    repeat (3) @(negedge clk);
    check("R7 addr", eff_addr, 0);
    check("R7 reg", {27'd0, elem_reg}, 0);
    check("R7 flags", {29'd0, load_stb, store_stb, unknown_op}, 0);
    rst_n = 1;
    drive(0, 0, 0, 0);
    @(negedge clk);

    // R1 R2 R3 R4 R8: back-to-back table
    for (int k = 0; k < NV; k++) begin
      drive(1, mk(0, V_RD[k], V_SH[k], V_ST[k] ? 6'h39 : 6'h38), V_BASE[k], V_IDX[k]);
      @(negedge clk);
      check("R2 R3 addr", eff_addr, ea(V_BASE[k], V_IDX[k], V_SH[k]));
      check("R4 reg", {27'd0, elem_reg}, {27'd0, V_RD[k]});
      check("R1 R8 strobes", {30'd0, load_stb, store_stb}, {30'd0, !V_ST[k], V_ST[k]});
    end
    drive(0, 0, 0, 0);
    @(negedge clk);
    check("R8 pulse ends", {30'd0, load_stb, store_stb}, 0);

    // R5 unknown func after known load
    drive(1, mk(0, 5'd21, 5'd2, 6'h38), 32'h500, 32'h10);
    @(negedge clk);
    hold_a = eff_addr; hold_r = elem_reg;
    check("R3 stride2", hold_a, 32'h520);
    drive(1, mk(0, 5'd3, 5'd8, 6'h20), 32'hAAAA, 32'h5);
    @(negedge clk);
    check("R5 flag func", {29'd0, load_stb, store_stb, unknown_op}, 1);
    check("R5 addr hold", eff_addr, hold_a);
    check("R5 reg hold", {27'd0, elem_reg}, {27'd0, hold_r});
    drive(1, mk(6'h23, 5'd3, 5'd8, 6'h38), 32'hBBBB, 32'h5);
    @(negedge clk);
    check("R5 flag opcode", {29'd0, load_stb, store_stb, unknown_op}, 1);
    check("R5 addr hold op", eff_addr, hold_a);

    // R6 valid low with load bits
    drive(0, mk(0, 5'd9, 5'd1, 6'h39), 32'hCCCC, 32'h1);
    @(negedge clk);
    check("R6 flags", {29'd0, load_stb, store_stb, unknown_op}, 0);
    check("R6 addr hold", eff_addr, hold_a);
    check("R6 reg hold", {27'd0, elem_reg}, {27'd0, hold_r});

    // R8 store then load consecutive, then unknown
    drive(1, mk(0, 5'd6, 5'd0, 6'h39), 32'h10, 32'h2);
    @(negedge clk);
    check("R8 st first", {30'd0, load_stb, store_stb}, 1);
    check("R3 zero-sh addr", eff_addr, 32'h50);
    drive(1, mk(0, 5'd8, 5'd1, 6'h38), 32'h10, 32'h2);
    @(negedge clk);
    check("R8 ld second", {30'd0, load_stb, store_stb}, 2);
    check("R2 stride1 addr", eff_addr, 32'h12);
    check("R4 reg second", {27'd0, elem_reg}, 8);
    drive(0, 0, 0, 0);
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule